// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from three active-low external pins and from five internal peripheral event lines: transmit and receive for two serial ports, and an interval timer. It keeps a pending flag for each of six priority slots and gates the flags with a per-slot enable mask. It then picks the highest-priority survivor and presents that slot's vector address to the instruction sequencer, together with a request strobe. The sequencer takes the request by raising an acknowledge. Later it signals the end of the service routine with a return pulse.

Each external pin can be set to edge or level sensitivity. The two lowest-priority external pins can replace the second serial port's events in their slots. Nested service is optional. When it is enabled, only a request of strictly higher priority than the routine in progress may interrupt that routine. The block's synchronous reset is the non-maskable startup event, and it leaves the vector output at address zero.

Top module: `irq_vec_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `irq_req` is 0 and `irq_vec` is 0x0000. No request is pending and no service is in progress.
- R2: Slot k (0 = highest priority) presents the vector 4*(k+1). The sources are assigned as follows: slot 0 is pin 2 (0x0004), slot 1 is port-0 transmit (0x0008), slot 2 is port-0 receive (0x000C), slot 3 is port-1 transmit or pin 1 (0x0010), slot 4 is port-1 receive or pin 0 (0x0014), and slot 5 is the timer (0x0018).
- R3: When several eligible slots are pending, the lowest slot index is presented.
- R4: Bit k of `mask_en` must be 1 for slot k to be presented. A masked latched request stays pending and is presented once its bit is set.
- R5: Bit p of `pin_edge` = 1 makes pin p edge-sensitive. A falling edge latches a request that stays pending after the pin returns high, until that slot is acknowledged.
- R6: Bit p of `pin_edge` = 0 makes pin p level-sensitive. The slot is pending only while the pin is low, and it is withdrawn when the pin goes high.
- R7: A cycle with `irq_req` and `ack` both high accepts the presented slot. `irq_req` is 0 on the next cycle, and the slot's edge latch is cleared.
- R8: With `nest_en` = 0, nothing is presented while any service is in progress.
- R9: With `nest_en` = 1, a slot is presented during service only if its index is lower than that of the most recently accepted slot still in service.
- R10: A pulse on `rti` ends the most recent service, so lower priorities can be presented again.
- R11: With `pin_alt` = 1, slots 3 and 4 take pins 1 and 0, and port-1 events are ignored. With `pin_alt` = 0, those pins are ignored.
- R12: External pins pass a two-stage synchronizer. A level-mode pin sampled low at one clock edge raises `irq_req` at the third edge, and `irq_req` is still 0 after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (startup event) |
| ext_irq_n | input | 3 | External interrupt pins, active low |
| pin_edge | input | 3 | Per-pin sensitivity, 1 = falling edge, 0 = low level |
| pin_alt | input | 1 | 1 = pins 1/0 drive slots 3/4 instead of port-1 events |
| sp0_tx_ev | input | 1 | Serial port 0 transmit event pulse |
| sp0_rx_ev | input | 1 | Serial port 0 receive event pulse |
| sp1_tx_ev | input | 1 | Serial port 1 transmit event pulse |
| sp1_rx_ev | input | 1 | Serial port 1 receive event pulse |
| tmr_ev | input | 1 | Timer event pulse |
| mask_en | input | 6 | Per-slot enable, bit k for slot k |
| nest_en | input | 1 | Allow higher-priority preemption |
| ack | input | 1 | Sequencer accepts the presented request |
| rti | input | 1 | Current service routine returns |
| irq_req | output | 1 | Request strobe to the sequencer |
| irq_vec | output | 16 | Vector address of the presented slot |

## Verification
The assertions assume that `rti` is only raised while a service is in progress, that `ack` and `rti` are never high in the same cycle, and that `mask_en` and `nest_en` change only while no request is presented. The directed tasks obey these rules. They pulse events for exactly one cycle, and they raise `ack` only while `irq_req` is seen high. Each scenario also ends every service it opened and releases every pin it drove before the next scenario starts.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SLOTS = 6;
  localparam int NUM_PINS  = 3;
  localparam int NUM_EVS   = 5;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  typedef logic [SLOT_W-1:0] slot_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic low_o,
  output logic fall_o
);
  logic [STAGES-1:0] shr;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      shr  <= '1;
      prev <= 1'b1;
    end else begin
      shr  <= {shr[STAGES-2:0], pin_n};
      prev <= shr[STAGES-1];
    end
  end

  assign low_o  = ~shr[STAGES-1];
  assign fall_o = prev & ~shr[STAGES-1];
endmodule

// File: rtl/irq_pend.sv
module irq_pend
  import irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PINS-1:0]  pin_low,
  input  logic [NUM_PINS-1:0]  pin_fall,
  input  logic [NUM_PINS-1:0]  pin_edge,
  input  logic                 pin_alt,
  input  logic [NUM_EVS-1:0]   evs,
  input  logic                 clr_vld,
  input  slot_t                clr_slot,
  output logic [NUM_SLOTS-1:0] pend_o
);
  logic [NUM_SLOTS-1:0] set_v, lvl_v, latch;
  logic [NUM_PINS-1:0]  pin_set, pin_lvl;

  assign pin_set = pin_fall & pin_edge;
  assign pin_lvl = pin_low & ~pin_edge;

  always_comb begin
    set_v[0] = pin_set[2];
    set_v[1] = evs[0];
    set_v[2] = evs[1];
    set_v[3] = pin_alt ? pin_set[1] : evs[2];
    set_v[4] = pin_alt ? pin_set[0] : evs[3];
    set_v[5] = evs[4];
    lvl_v    = '0;
    lvl_v[0] = pin_lvl[2];
    lvl_v[3] = pin_alt & pin_lvl[1];
    lvl_v[4] = pin_alt & pin_lvl[0];
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_latch
    always_ff @(posedge clk) begin
      if (rst) latch[s] <= 1'b0;
      else     latch[s] <= set_v[s] | (latch[s] & ~(clr_vld && clr_slot == slot_t'(s)));
    end
  end

  assign pend_o = latch | lvl_v;
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SLOT_WORDS = 4
) (
  input  logic [NUM_SLOTS-1:0] pend,
  input  logic [NUM_SLOTS-1:0] mask_en,
  input  logic [NUM_SLOTS-1:0] in_svc,
  input  logic                 nest_en,
  output logic                 any_o,
  output slot_t                slot_o,
  output logic [ADDR_W-1:0]    vec_o
);
  slot_t                top;
  logic [NUM_SLOTS-1:0] elig;

  always_comb begin
    top = slot_t'(NUM_SLOTS - 1);
    for (int i = NUM_SLOTS - 1; i >= 0; i--)
      if (in_svc[i]) top = slot_t'(i);
    for (int i = 0; i < NUM_SLOTS; i++)
      elig[i] = pend[i] & mask_en[i] &
                ((in_svc == '0) | (nest_en & (slot_t'(i) < top)));
    slot_o = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--)
      if (elig[i]) slot_o = slot_t'(i);
    any_o = |elig;
    vec_o = ADDR_W'((32'(slot_o) + 32'd1) * SLOT_WORDS);
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SLOT_WORDS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PINS-1:0]  ext_irq_n,
  input  logic [NUM_PINS-1:0]  pin_edge,
  input  logic                 pin_alt,
  input  logic                 sp0_tx_ev,
  input  logic                 sp0_rx_ev,
  input  logic                 sp1_tx_ev,
  input  logic                 sp1_rx_ev,
  input  logic                 tmr_ev,
  input  logic [NUM_SLOTS-1:0] mask_en,
  input  logic                 nest_en,
  input  logic                 ack,
  input  logic                 rti,
  output logic                 irq_req,
  output logic [ADDR_W-1:0]    irq_vec
);
  logic [NUM_PINS-1:0]  pin_low, pin_fall;
  logic [NUM_SLOTS-1:0] pend, in_svc, svc_nxt;
  logic                 any, accept;
  slot_t                sel_slot, cur_slot;
  logic [ADDR_W-1:0]    sel_vec;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .pin_n(ext_irq_n[p]),
      .low_o(pin_low[p]), .fall_o(pin_fall[p]));
  end

  assign accept = irq_req & ack;

  irq_pend u_pend (
    .clk(clk), .rst(rst), .pin_low(pin_low), .pin_fall(pin_fall),
    .pin_edge(pin_edge), .pin_alt(pin_alt),
    .evs({tmr_ev, sp1_rx_ev, sp1_tx_ev, sp0_rx_ev, sp0_tx_ev}),
    .clr_vld(accept), .clr_slot(cur_slot), .pend_o(pend));

  irq_arb #(.ADDR_W(ADDR_W), .SLOT_WORDS(SLOT_WORDS)) u_arb (
    .pend(pend), .mask_en(mask_en), .in_svc(in_svc), .nest_en(nest_en),
    .any_o(any), .slot_o(sel_slot), .vec_o(sel_vec));

  always_comb begin
    svc_nxt = rti ? (in_svc & (in_svc - 1'b1)) : in_svc;
    if (accept) svc_nxt[cur_slot] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_svc   <= '0;
      irq_req  <= 1'b0;
      irq_vec  <= '0;
      cur_slot <= '0;
    end else begin
      in_svc  <= svc_nxt;
      irq_req <= any & ~accept;
      if (any) begin
        irq_vec  <= sel_vec;
        cur_slot <= sel_slot;
      end
    end
  end
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk
  import irq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SLOT_WORDS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_SLOTS-1:0] mask_en,
  input logic                 nest_en,
  input logic                 ack,
  input logic                 rti,
  input logic                 irq_req,
  input logic [ADDR_W-1:0]    irq_vec,
  input logic [NUM_SLOTS-1:0] in_svc
);
  logic [NUM_SLOTS-1:0] mask_q;
  slot_t                vslot;

  always_ff @(posedge clk) mask_q <= mask_en;
  assign vslot = slot_t'((32'(irq_vec) / SLOT_WORDS) - 1);

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!irq_req && irq_vec == '0));

  p_vec_grid_r2: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> ((32'(irq_vec) % SLOT_WORDS) == 0 && irq_vec != '0 &&
                 32'(irq_vec) <= NUM_SLOTS * SLOT_WORDS));

  p_masked_hidden_r4: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> mask_q[vslot]);

  p_accept_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_req && ack) |=> !irq_req);

  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    (!nest_en && in_svc != '0) |=> !irq_req);

  p_return_pops_r10: assert property (@(posedge clk) disable iff (rst)
    (rti && !(irq_req && ack) && in_svc != '0) |=>
      ($countones(in_svc) + 1 == $past($countones(in_svc))));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.ADDR_W(ADDR_W), .SLOT_WORDS(SLOT_WORDS)) u_chk (
  .clk(clk), .rst(rst), .mask_en(mask_en), .nest_en(nest_en), .ack(ack),
  .rti(rti), .irq_req(irq_req), .irq_vec(irq_vec), .in_svc(in_svc));

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic [2:0]  ext_irq_n = 3'b111;
  logic [2:0]  pin_edge = 3'b111;
  logic        pin_alt = 0;
  logic [4:0]  evs = '0;
  logic [5:0]  mask_en = 6'h3F;
  logic        nest_en = 0, ack = 0, rti = 0;
  logic        irq_req;
  logic [15:0] irq_vec;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_vec_ctrl u_dut (
    .clk(clk), .rst(rst), .ext_irq_n(ext_irq_n), .pin_edge(pin_edge),
    .pin_alt(pin_alt), .sp0_tx_ev(evs[0]), .sp0_rx_ev(evs[1]),
    .sp1_tx_ev(evs[2]), .sp1_rx_ev(evs[3]), .tmr_ev(evs[4]),
    .mask_en(mask_en), .nest_en(nest_en), .ack(ack), .rti(rti),
    .irq_req(irq_req), .irq_vec(irq_vec));

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_req(int lim);
    for (int i = 0; i < lim && !irq_req; i++) step(1);
  endtask

  task automatic take();
    ack = 1; step(1); ack = 0;
  endtask

  task automatic ret();
    rti = 1; step(1); rti = 0;
  endtask

  task automatic pulse(int k);
    evs[k] = 1; step(1); evs = '0;
  endtask

  task automatic t_reset();
    chk(irq_req == 0 && irq_vec == 16'h0, "R1 reset idle", {irq_req, irq_vec[14:0]}, 16'h0);
  endtask

  task automatic t_vectors();
    logic [15:0] exp_v [5] = '{16'h0008, 16'h000C, 16'h0010, 16'h0014, 16'h0018};
    pin_edge[2] = 0; ext_irq_n[2] = 0;
    wait_req(8);
    chk(irq_req && irq_vec == 16'h0004, "R2 slot0 vector", irq_vec, 16'h0004);
    take(); ext_irq_n[2] = 1; step(4); ret(); pin_edge[2] = 1;
    for (int k = 0; k < 5; k++) begin
      pulse(k); wait_req(6);
      chk(irq_req && irq_vec == exp_v[k], "R2 peripheral vector", irq_vec, exp_v[k]);
      take(); step(1); ret(); step(1);
    end
  endtask

  task automatic t_priority();
    evs[4] = 1; evs[1] = 1; step(1); evs = '0;
    wait_req(6);
    chk(irq_vec == 16'h000C, "R3 higher slot wins", irq_vec, 16'h000C);
    take(); step(1); ret();
    wait_req(6);
    chk(irq_req && irq_vec == 16'h0018, "R3 loser follows", irq_vec, 16'h0018);
    take(); step(1); ret(); step(2);
  endtask

  task automatic t_mask();
    mask_en[1] = 0; pulse(0); step(5);
    chk(irq_req == 0, "R4 masked hidden", 16'(irq_req), 16'h0);
    mask_en[1] = 1; wait_req(6);
    chk(irq_req && irq_vec == 16'h0008, "R4 kept pending", irq_vec, 16'h0008);
    take(); step(1); ret(); step(2);
  endtask

  task automatic t_level();
    pin_edge[2] = 0; ext_irq_n[2] = 0;
    step(2);
    chk(irq_req == 0, "R12 not before third edge", 16'(irq_req), 16'h0);
    step(1);
    chk(irq_req == 1, "R12 raised on third edge", 16'(irq_req), 16'h1);
    ext_irq_n[2] = 1; step(4);
    chk(irq_req == 0, "R6 withdrawn when high", 16'(irq_req), 16'h0);
    pin_edge[2] = 1; step(2);
  endtask

  task automatic t_edge();
    ext_irq_n[2] = 0; step(3); ext_irq_n[2] = 1; step(6);
    chk(irq_req && irq_vec == 16'h0004, "R5 edge latched", irq_vec, 16'h0004);
    take();
    chk(irq_req == 0, "R7 drop after accept", 16'(irq_req), 16'h0);
    ret(); step(4);
    chk(irq_req == 0, "R7 latch cleared", 16'(irq_req), 16'h0);
  endtask

  task automatic t_no_nest();
    pulse(4); wait_req(6); take();
    pulse(0); step(4);
    chk(irq_req == 0, "R8 no preempt", 16'(irq_req), 16'h0);
    ret(); wait_req(6);
    chk(irq_req && irq_vec == 16'h0008, "R8 after return", irq_vec, 16'h0008);
    take(); step(1); ret(); step(2);
  endtask

  task automatic t_nest();
    nest_en = 1;
    pulse(4); wait_req(6); take();
    pulse(1); wait_req(6);
    chk(irq_req && irq_vec == 16'h000C, "R9 preempt higher", irq_vec, 16'h000C);
    take();
    pulse(2); step(4);
    chk(irq_req == 0, "R9 lower blocked", 16'(irq_req), 16'h0);
    ret(); wait_req(6);
    chk(irq_req && irq_vec == 16'h0010, "R10 pop reenables", irq_vec, 16'h0010);
    take(); step(1); ret(); ret(); step(3);
    chk(irq_req == 0, "R10 all returned idle", 16'(irq_req), 16'h0);
    nest_en = 0;
  endtask

  task automatic t_alt();
    pin_alt = 1; step(1);
    pulse(2); step(4);
    chk(irq_req == 0, "R11 port1 event ignored", 16'(irq_req), 16'h0);
    ext_irq_n[1] = 0; step(3); ext_irq_n[1] = 1; wait_req(6);
    chk(irq_req && irq_vec == 16'h0010, "R11 pin1 in slot3", irq_vec, 16'h0010);
    take(); step(1); ret(); step(2);
    pin_edge[0] = 0; ext_irq_n[0] = 0; wait_req(8);
    chk(irq_req && irq_vec == 16'h0014, "R11 pin0 level in slot4", irq_vec, 16'h0014);
    take(); ext_irq_n[0] = 1; step(4); ret(); step(2);
    pin_alt = 0; step(1);
    ext_irq_n[0] = 0; step(6);
    chk(irq_req == 0, "R11 pin ignored when not selected", 16'(irq_req), 16'h0);
    ext_irq_n[0] = 1; pin_edge[0] = 1; step(3);
  endtask

  initial begin
    step(4);
    t_reset();
    rst = 0; step(1);
    t_reset();
    t_vectors();
    t_priority();
    t_mask();
    t_level();
    t_edge();
    t_no_nest();
    t_nest();
    t_alt();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule